// File: doc/BRIEF.md
# SRAM Write-Cycle Timing Monitor

This block watches the control, address and data lines of an asynchronous static RAM interface. It takes no part in the interface. A fast reference clock samples every line, and a free-running tick counter stamps each edge. From these timestamps the block measures each write cycle and compares it with minimum limits. All limits are parameters counted in reference-clock ticks.

A write is active only while chip select and write enable are both low. The write therefore starts at whichever of the two falls last and ends at whichever rises first. Some intervals are known when the write ends: the pulse width, the chip-select width, the data setup and address stability. The recovery and total cycle time are known only at the next address change. The block holds the results of a cycle until the cycle closes, and then reports them once. It keeps a sticky flag for each rule, a one-cycle pulse for each offending cycle, and a count of offending cycles.

Top module: `sram_write_monitor`

## Requirements
- R1: A write window opens on the sample where chip select and write enable are both first seen low. It closes on the first sample where either is high again. The pulse width is the tick count between those two samples, whichever signal moves first.
- R2: The pulse-width flag (bit 0 of `viol_flags`) is set when the window is shorter than `T_WP` ticks, provided output enable was not low for the whole window.
- R3: When output enable was low on every sample of the window, the pulse-width limit becomes `T_DW + T_WHZ` ticks. If output enable goes high at any point in the window, `T_WP` applies.
- R4: Bit 1 is set when fewer than `T_CW` ticks separate the last falling edge of chip select from the end of the window.
- R5: Bit 2 is set when fewer than `T_DW` ticks separate the last change on the data lines from the end of the window.
- R6: Bit 3 is set when the first address change after the window comes fewer than `T_WR` ticks after the window ends.
- R7: Bit 4 is set when fewer than `T_WC` ticks separate the address change that preceded the window from the first address change after it.
- R8: Bit 5 is set when the address changes while the window is open.
- R9: Flags stay set until `clear` is sampled high. On that edge all flags and `viol_count` become zero.
- R10: A write cycle closes at the first address change after its window. If that cycle broke any rule, `viol_pulse` is high for exactly one clock and `viol_count` rises by one, saturating at its maximum. A cycle that breaks no rule produces neither.
- R11: If a new window opens before any address change, the pending cycle closes at that opening. In that case only bits 0, 1, 2 and 5 are judged, and recovery and cycle time are not checked.
- R12: After reset, `viol_flags`, `viol_pulse` and `viol_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of flags and counter |
| cs_n | input | 1 | Observed chip select, active low |
| we_n | input | 1 | Observed write enable, active low |
| oe_n | input | 1 | Observed output enable, active low |
| addr | input | AW | Observed address lines |
| data | input | DW | Observed data lines |
| viol_flags | output | 6 | Sticky per-rule violation flags (bit map in R2 to R8) |
| viol_pulse | output | 1 | One-clock pulse when a violating cycle closes |
| viol_count | output | CNTW | Saturating count of violating cycles |

## Verification
Some properties hold on every clock, and the checker tests those continuously. The flags never drop without a clear, a clear empties both the flags and the counter, and the pulse lasts one clock and comes with nonzero flags. The counter moves only on a pulse or a clear. Whether each flag is right for a given set of intervals can only be shown by the bench's scenarios. The bench sweeps the edge order, pulse width, data setup, recovery and output-enable level, and computes the expected flag word for each cycle. Separate scenarios cover staggered release, address glitches inside a window, and cycles that close on the next write.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;
  localparam int NCHK = 6;

  // Bit positions inside the violation flag word
  typedef enum int unsigned {
    CHK_PULSE = 0,
    CHK_CSW   = 1,
    CHK_SETUP = 2,
    CHK_RECOV = 3,
    CHK_CYCLE = 4,
    CHK_ADDR  = 5
  } chk_e;
endpackage

// File: rtl/sram_mon_sampler.sv
module sram_mon_sampler #(
  parameter int AW   = 19,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          oe_low,
  output logic          cs_fall,
  output logic          win_open,
  output logic          win_close,
  output logic          addr_chg,
  output logic          data_chg
);
  localparam int W  = 3 + AW + DW;
  localparam int CS = W - 1;
  localparam int WE = W - 2;
  localparam int OE = W - 3;
  localparam logic [W-1:0] IDLE = {3'b111, {(AW + DW){1'b0}}};

  logic [W-1:0]            pins;
  logic [SYNC-1:0][W-1:0]  chain;
  logic [W-1:0]            cur, prv;
  logic                    act_c, act_p;

  assign pins = {cs_n, we_n, oe_n, addr, data};

  // Synchroniser chain followed by one history stage
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {SYNC{IDLE}};
      prv   <= IDLE;
    end else begin
      chain[0] <= pins;
      for (int i = 1; i < SYNC; i++) chain[i] <= chain[i-1];
      prv <= chain[SYNC-1];
    end
  end

  assign cur   = chain[SYNC-1];
  assign act_c = ~cur[CS] & ~cur[WE];
  assign act_p = ~prv[CS] & ~prv[WE];

  assign oe_low    = ~cur[OE];
  assign cs_fall   = ~cur[CS] & prv[CS];
  assign win_open  = act_c & ~act_p;
  assign win_close = ~act_c & act_p;
  assign addr_chg  = cur[AW+DW-1:DW] != prv[AW+DW-1:DW];
  assign data_chg  = cur[DW-1:0] != prv[DW-1:0];
endmodule

// File: rtl/sram_mon_tracker.sv
module sram_mon_tracker #(
  parameter int TSW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_fall,
  input  logic           win_open,
  input  logic           win_close,
  input  logic           addr_chg,
  input  logic           data_chg,
  input  logic           oe_low,
  output logic           end_evt,
  output logic           close_evt,
  output logic           close_tail,
  output logic [TSW-1:0] pw_len,
  output logic [TSW-1:0] cs_len,
  output logic [TSW-1:0] setup_len,
  output logic [TSW-1:0] recov_len,
  output logic [TSW-1:0] cycle_len,
  output logic           oe_held,
  output logic           addr_moved
);
  logic [TSW-1:0] now, t_cs, t_dat, t_addr, t_start, t_open, t_end;
  logic           in_win, pend;

  assign close_evt  = pend & (addr_chg | win_open);
  assign close_tail = addr_chg;
  assign end_evt    = win_close;

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0; t_cs <= '0; t_dat <= '0; t_addr <= '0;
      t_start <= '0; t_open <= '0; t_end <= '0;
      in_win <= 1'b0; pend <= 1'b0; oe_held <= 1'b0; addr_moved <= 1'b0;
    end else begin
      now <= now + 1'b1;
      if (cs_fall)  t_cs   <= now;
      if (data_chg) t_dat  <= now;
      if (addr_chg) t_addr <= now;
      if (win_open) begin
        in_win     <= 1'b1;
        t_start    <= now;
        t_open     <= t_addr;
        oe_held    <= oe_low;
        addr_moved <= 1'b0;
      end else if (win_close) begin
        in_win <= 1'b0;
        t_end  <= now;
      end else if (in_win) begin
        if (!oe_low)  oe_held    <= 1'b0;
        if (addr_chg) addr_moved <= 1'b1;
      end
      if (win_close)      pend <= 1'b1;
      else if (close_evt) pend <= 1'b0;
    end
  end

  assign pw_len    = now - t_start;
  assign cs_len    = now - t_cs;
  assign setup_len = now - t_dat;
  assign recov_len = now - t_end;
  assign cycle_len = now - t_open;
endmodule

// File: rtl/sram_mon_judge.sv
module sram_mon_judge
  import sram_mon_pkg::*;
#(
  parameter int TSW   = 12,
  parameter int CNTW  = 16,
  parameter int T_WP  = 40,
  parameter int T_CW  = 50,
  parameter int T_DW  = 25,
  parameter int T_WHZ = 20,
  parameter int T_WR  = 5,
  parameter int T_WC  = 55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            end_evt,
  input  logic            close_evt,
  input  logic            close_tail,
  input  logic [TSW-1:0]  pw_len,
  input  logic [TSW-1:0]  cs_len,
  input  logic [TSW-1:0]  setup_len,
  input  logic [TSW-1:0]  recov_len,
  input  logic [TSW-1:0]  cycle_len,
  input  logic            oe_held,
  input  logic            addr_moved,
  output logic [NCHK-1:0] flags,
  output logic            pulse,
  output logic [CNTW-1:0] count
);
  localparam logic [TSW-1:0] LIM_WP   = TSW'(T_WP);
  localparam logic [TSW-1:0] LIM_WPOE = TSW'(T_DW + T_WHZ);
  localparam logic [TSW-1:0] LIM_CW   = TSW'(T_CW);
  localparam logic [TSW-1:0] LIM_DW   = TSW'(T_DW);
  localparam logic [TSW-1:0] LIM_WR   = TSW'(T_WR);
  localparam logic [TSW-1:0] LIM_WC   = TSW'(T_WC);

  logic [NCHK-1:0] end_bits, tail_bits, pend_bits, close_bits;

  always_comb begin
    end_bits            = '0;
    end_bits[CHK_PULSE] = pw_len < (oe_held ? LIM_WPOE : LIM_WP);
    end_bits[CHK_CSW]   = cs_len < LIM_CW;
    end_bits[CHK_SETUP] = setup_len < LIM_DW;
    end_bits[CHK_ADDR]  = addr_moved;
    tail_bits           = '0;
    if (close_tail) begin
      tail_bits[CHK_RECOV] = recov_len < LIM_WR;
      tail_bits[CHK_CYCLE] = cycle_len < LIM_WC;
    end
    close_bits = pend_bits | tail_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_bits <= '0;
      flags     <= '0;
      pulse     <= 1'b0;
      count     <= '0;
    end else begin
      pulse <= 1'b0;
      if (end_evt) pend_bits <= end_bits;
      if (clear) begin
        flags <= '0;
        count <= '0;
      end else if (close_evt) begin
        flags <= flags | close_bits;
        pulse <= |close_bits;
        if (|close_bits && count != {CNTW{1'b1}}) count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_write_monitor.sv
module sram_write_monitor
  import sram_mon_pkg::*;
#(
  parameter int AW    = 19,
  parameter int DW    = 8,
  parameter int SYNC  = 2,
  parameter int TSW   = 12,
  parameter int CNTW  = 16,
  parameter int T_WP  = 40,
  parameter int T_CW  = 50,
  parameter int T_DW  = 25,
  parameter int T_WHZ = 20,
  parameter int T_WR  = 5,
  parameter int T_WC  = 55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            cs_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data,
  output logic [NCHK-1:0] viol_flags,
  output logic            viol_pulse,
  output logic [CNTW-1:0] viol_count
);
  logic           oe_low, cs_fall, win_open, win_close, addr_chg, data_chg;
  logic           end_evt, close_evt, close_tail, oe_held, addr_moved;
  logic [TSW-1:0] pw_len, cs_len, setup_len, recov_len, cycle_len;

  sram_mon_sampler #(.AW(AW), .DW(DW), .SYNC(SYNC)) u_smp (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .oe_low(oe_low), .cs_fall(cs_fall),
    .win_open(win_open), .win_close(win_close),
    .addr_chg(addr_chg), .data_chg(data_chg)
  );

  sram_mon_tracker #(.TSW(TSW)) u_trk (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .win_open(win_open),
    .win_close(win_close), .addr_chg(addr_chg), .data_chg(data_chg),
    .oe_low(oe_low), .end_evt(end_evt), .close_evt(close_evt),
    .close_tail(close_tail), .pw_len(pw_len), .cs_len(cs_len),
    .setup_len(setup_len), .recov_len(recov_len), .cycle_len(cycle_len),
    .oe_held(oe_held), .addr_moved(addr_moved)
  );

  sram_mon_judge #(
    .TSW(TSW), .CNTW(CNTW), .T_WP(T_WP), .T_CW(T_CW), .T_DW(T_DW),
    .T_WHZ(T_WHZ), .T_WR(T_WR), .T_WC(T_WC)
  ) u_jdg (
    .clk(clk), .rst(rst), .clear(clear), .end_evt(end_evt),
    .close_evt(close_evt), .close_tail(close_tail), .pw_len(pw_len),
    .cs_len(cs_len), .setup_len(setup_len), .recov_len(recov_len),
    .cycle_len(cycle_len), .oe_held(oe_held), .addr_moved(addr_moved),
    .flags(viol_flags), .pulse(viol_pulse), .count(viol_count)
  );
endmodule

// File: rtl/sram_write_monitor_chk.sv
module sram_write_monitor_chk
  import sram_mon_pkg::*;
#(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            clear,
  input logic [NCHK-1:0] viol_flags,
  input logic            viol_pulse,
  input logic [CNTW-1:0] viol_count
);
  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (viol_flags == '0 && viol_count == '0));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  // R10
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_flags != '0);

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |=> !viol_pulse);

  // R10
  count_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_count != $past(viol_count)) |-> (viol_pulse || $past(clear)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (viol_flags == '0 && !viol_pulse && viol_count == '0));
endmodule

bind sram_write_monitor sram_write_monitor_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .viol_flags(viol_flags),
  .viol_pulse(viol_pulse), .viol_count(viol_count)
);

// File: tb/sram_write_monitor_test.sv
module sram_write_monitor_test;
  localparam int AW = 6, DW = 4, TSW = 10, CNTW = 8;
  localparam int T_WP = 4, T_CW = 5, T_DW = 3, T_WHZ = 2, T_WR = 2, T_WC = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, clear = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [5:0] viol_flags;
  logic viol_pulse;
  logic [CNTW-1:0] viol_count;

  sram_write_monitor #(
    .AW(AW), .DW(DW), .SYNC(2), .TSW(TSW), .CNTW(CNTW), .T_WP(T_WP),
    .T_CW(T_CW), .T_DW(T_DW), .T_WHZ(T_WHZ), .T_WR(T_WR), .T_WC(T_WC)
  ) uut (
    .clk(clk), .rst(rst), .clear(clear), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .data(data), .viol_flags(viol_flags),
    .viol_pulse(viol_pulse), .viol_count(viol_count)
  );

  int checks = 0, failures = 0, pulses = 0, cycles = 0;

  always @(negedge clk) if (!rst && viol_pulse) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog R1 R10 actual=%0d expected<190000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    repeat (2) @(negedge clk);
    pulses = 0;
  endtask

  // One write cycle; tick 0 is the opening address change (if open_addr).
  task automatic run_cycle(input int we_first, input int lead, input int pw,
                           input int dset, input int wr, input int oe_low,
                           input int oe_mid, input int glitch, input int stagger,
                           input int open_addr, output logic [5:0] e);
    int ts, te, last, minwp, cw;
    ts = 1 + lead;
    te = ts + pw;
    last = (wr > 0) ? te + wr : te + stagger;
    for (int t = 0; t <= last; t++) begin
      if (t == 0 && open_addr != 0) addr = addr + 6'd4;
      if (t == 0) oe_n = (oe_low != 0) ? 1'b0 : 1'b1;
      if (t == 1) begin
        if (we_first != 0) we_n = 1'b0; else cs_n = 1'b0;
      end
      if (t == ts) begin cs_n = 1'b0; we_n = 1'b0; end
      if (t == te - dset) data = data + 4'd1;
      if (glitch != 0 && t == ts + 1) addr = addr ^ 6'd1;
      if (oe_mid != 0 && t == ts + 1) oe_n = 1'b1;
      if (t == te) begin
        cs_n = 1'b1;
        if (stagger == 0) we_n = 1'b1;
      end
      if (stagger != 0 && t == te + 1) we_n = 1'b1;
      if (wr > 0 && t == te + wr) addr = addr + 6'd4;
      @(negedge clk);
    end
    minwp = (oe_low != 0 && oe_mid == 0) ? T_DW + T_WHZ : T_WP;
    cw = (we_first != 0 || lead == 0) ? pw : lead + pw;
    e[0] = pw < minwp;
    e[1] = cw < T_CW;
    e[2] = dset < T_DW;
    e[3] = (wr > 0) && (wr < T_WR);
    e[4] = (wr > 0) && ((te + wr) < T_WC);
    e[5] = glitch != 0;
  endtask

  task automatic settle_check(input string req, input logic [5:0] ef,
                              input int ep, input int ec);
    repeat (6) @(negedge clk);
    expect_eq({req, " flags"}, int'(viol_flags), int'(ef));
    expect_eq("R10 pulses", pulses, ep);
    expect_eq("R10 count", int'(viol_count), ec);
  endtask

  initial begin
    logic [5:0] e1, e2, e3;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    expect_eq("R12 flags", int'(viol_flags), 0);
    expect_eq("R12 pulse", int'(viol_pulse), 0);
    expect_eq("R12 count", int'(viol_count), 0);

    // R1 R2 R3 R4 R5 R6 R7: sweep edge order, width, setup, recovery, OE level
    for (int wf = 0; wf < 2; wf++)
      for (int ld = 0; ld < 3; ld++)
        for (int pw = 1; pw <= 6; pw++)
          for (int oe = 0; oe < 2; oe++)
            for (int ds = 1; ds <= pw; ds++)
              for (int wr = 1; wr <= 3; wr++) begin
                do_clear();
                run_cycle(wf, ld, pw, ds, wr, oe, 0, 0, 0, 1, e1);
                settle_check("R1 R2 R3 R4 R5 R6 R7", e1, (e1 != 0) ? 1 : 0,
                             (e1 != 0) ? 1 : 0);
              end

    // R1: chip select releases first, write enable one tick later
    for (int pw = 2; pw <= 6; pw++) begin
      do_clear();
      run_cycle(0, 1, pw, 2, 2, 0, 0, 0, 1, 1, e1);
      settle_check("R1 staggered", e1, (e1 != 0) ? 1 : 0, (e1 != 0) ? 1 : 0);
    end

    // R8: address glitch inside the window
    for (int pw = 2; pw <= 5; pw++) begin
      do_clear();
      run_cycle(0, 2, pw, 1 + pw / 2, 3, 0, 0, 1, 0, 1, e1);
      settle_check("R8 glitch", e1, 1, 1);
    end

    // R3: OE low at open but high mid-window uses the plain limit
    do_clear();
    run_cycle(0, 1, 4, 3, 2, 1, 1, 0, 0, 1, e1);
    settle_check("R3 oe mid", e1, 0, 0);
    do_clear();
    run_cycle(0, 1, 4, 3, 2, 1, 0, 0, 0, 1, e1);
    settle_check("R3 oe whole", e1, 1, 1);

    // R11: cycle closed by the next write with no address change
    do_clear();
    run_cycle(0, 0, 2, 2, 0, 0, 0, 0, 0, 1, e1);
    run_cycle(0, 0, 5, 3, 3, 0, 0, 0, 0, 0, e2);
    settle_check("R11 close by write", e1 | e2, ((e1 != 0) ? 1 : 0) + ((e2 != 0) ? 1 : 0),
                 ((e1 != 0) ? 1 : 0) + ((e2 != 0) ? 1 : 0));

    // R9: flags stay after a clean cycle, then clear empties them
    do_clear();
    run_cycle(0, 0, 1, 1, 1, 0, 0, 0, 0, 1, e1);
    run_cycle(0, 1, 6, 3, 2, 0, 0, 0, 0, 1, e2);
    settle_check("R9 sticky", e1 | e2, 1, 1);
    do_clear();
    expect_eq("R9 cleared flags", int'(viol_flags), 0);
    expect_eq("R9 cleared count", int'(viol_count), 0);

    // R10: count accumulates across violating cycles
    run_cycle(1, 0, 1, 1, 1, 0, 0, 0, 0, 1, e1);
    run_cycle(0, 2, 3, 1, 3, 0, 0, 0, 0, 1, e2);
    run_cycle(0, 0, 6, 3, 1, 1, 0, 0, 0, 1, e3);
    settle_check("R10 accumulate", e1 | e2 | e3, 3, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule